// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vector memory instruction into a stream of per-element byte addresses. A single start strobe captures a base address, an addressing mode, an element size, a signed stride, an element count and a post-increment amount. The block then emits one address per cycle to the memory side over a valid/ready handshake, tagged with the element number, until the whole vector has been covered.

Three patterns share the same engine. Unit stride walks contiguous elements. Constant stride steps by any signed byte distance, for example 3 bytes to pull one channel out of packed RGB pixels. Indexed mode adds a streamed per-element offset to the base for gather and scatter. With the final element the block raises a completion flag and presents the base value advanced by the post-increment amount, so the register file can write it back. Translation, the DRAM access and data alignment happen elsewhere.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_done` and `idx_ready` are all low.
- R2: With `mode`=0 (unit stride), element i's address is `base + i*(1<<esize)`, where `esize` 0/1/2/3 means 1/2/4/8-byte elements.
- R3: With `mode`=1 (constant stride), element i's address is `base + i*stride`, where `stride` is a two's-complement byte count and the sum wraps modulo 2^AW. Odd strides such as 3 and negative strides are allowed.
- R4: With `mode`=2 or 3 (indexed), element i's address is `base + idx_data`, where `idx_data` is the offset for element i, unscaled. `out_valid` is low while `idx_valid` is low, and `idx_ready` is high only in a cycle where the element is accepted.
- R5: `out_tag` equals the element number modulo 2^TAGW, starting at 0, so it wraps to 0 at element 64 with the defaults.
- R6: One element is accepted per cycle while `out_ready` is high. While `out_ready` is low, `out_addr` and `out_tag` hold their values.
- R7: `out_done` is high together with the last element only, and `new_base` equals `base + incr` in that cycle.
- R8: A `start` while `busy` is high is ignored. The running sequence keeps its addresses, its count and its `new_base`.
- R9: A `start` with `vlen`=0 is ignored: `busy` stays low and no element is emitted.
- R10: In the cycle after the last element is accepted, `busy` is low and a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new vector when idle |
| mode | input | 2 | 0 unit stride, 1 constant stride, 2/3 indexed |
| esize | input | 2 | Element size code: 1, 2, 4 or 8 bytes |
| base | input | AW | Starting byte address |
| stride | input | AW | Signed byte stride for mode 1 |
| vlen | input | VLW | Number of elements |
| incr | input | AW | Post-increment added to the base |
| idx_valid | input | 1 | Index offset available |
| idx_data | input | AW | Byte offset of the current element |
| idx_ready | output | 1 | Index offset consumed this cycle |
| out_valid | output | 1 | Element address valid |
| out_ready | input | 1 | Memory side accepts the address |
| out_addr | output | AW | Element byte address |
| out_tag | output | TAGW | Element number modulo 2^TAGW |
| out_done | output | 1 | Current element is the last one |
| new_base | output | AW | Updated base, valid with `out_done` |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest situation to reach from the ports is a stall that meets other events: `out_ready` is low in the middle of a vector, the index stream runs dry, or `start` is pulsed again while elements are still pending. The bench runs a table of vectors across all modes and sizes, including a negative stride and a 70-element run that wraps the tag. Directed sequences then drop `out_ready` and `idx_valid` mid-vector and issue a conflicting start during a run. At each point they check that the address, the tag and the updated base stay on the original sequence.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW   = 32,
  parameter int VLW  = 7,
  parameter int TAGW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [1:0]      esize,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [VLW-1:0]  vlen,
  input  logic [AW-1:0]   incr,
  input  logic            idx_valid,
  input  logic [AW-1:0]   idx_data,
  output logic            idx_ready,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic [TAGW-1:0] out_tag,
  output logic            out_done,
  output logic [AW-1:0]   new_base,
  output logic            busy
);

  localparam logic [1:0] M_UNIT = 2'd0;

  logic           busy_q, idxm_q;
  logic [AW-1:0]  base_q, step_q, incr_q, cur_q;
  logic [VLW-1:0] cnt_q, last_q;
  logic           fire, at_last;

  assign at_last   = (cnt_q == last_q);
  assign out_valid = busy_q && (!idxm_q || idx_valid);
  assign fire      = out_valid && out_ready;
  assign idx_ready = busy_q && idxm_q && idx_valid && out_ready;
  assign out_addr  = idxm_q ? (base_q + idx_data) : cur_q;
  assign out_tag   = cnt_q[TAGW-1:0];
  assign out_done  = out_valid && at_last;
  assign new_base  = base_q + incr_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idxm_q <= 1'b0;
      base_q <= '0;
      step_q <= '0;
      incr_q <= '0;
      cur_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (start && vlen != '0) begin
        busy_q <= 1'b1;
        idxm_q <= mode[1];
        base_q <= base;
        cur_q  <= base;
        step_q <= (mode == M_UNIT) ? (AW'(1) << esize) : stride;
        incr_q <= incr;
        cnt_q  <= '0;
        last_q <= vlen - 1'b1;
      end
    end else if (fire) begin
      cur_q <= cur_q + step_q;
      cnt_q <= cnt_q + 1'b1;
      if (at_last) busy_q <= 1'b0;
    end
  end

  a_r1_valid_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !idxm_q) |=> (out_valid && $stable(out_addr) && $stable(out_tag)));

  a_r5_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_done) |=> (out_tag == $past(out_tag) + 1'b1));

  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_done) |=> !busy);

  a_r8_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(fire && out_done)) |=> $stable(new_base));

  a_r9_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && vlen == '0) |=> !busy);

endmodule

// File: tb/vec_addr_gen_tb.sv
`timescale 1ns/1ps
module vec_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0, esize = '0;
  logic [31:0] base = '0, stride = '0, incr = '0, idx_data = '0;
  logic [6:0]  vlen = '0;
  logic        idx_valid = 1'b0, out_ready = 1'b0;
  logic        idx_ready, out_valid, out_done, busy;
  logic [31:0] out_addr, new_base;
  logic [5:0]  out_tag;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  vec_addr_gen dut_i (.clk, .rst_n, .start, .mode, .esize, .base, .stride, .vlen,
    .incr, .idx_valid, .idx_data, .idx_ready, .out_valid, .out_ready, .out_addr,
    .out_tag, .out_done, .new_base, .busy);

  typedef struct packed {
    logic [1:0]  md;
    logic [1:0]  es;
    logic [31:0] bs;
    logic [31:0] st;
    logic [6:0]  n;
    logic [31:0] inc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd0, 32'h0000_1000, 32'd0,         7'd5,  32'd5},
    '{2'd0, 2'd1, 32'h0000_1800, 32'd0,         7'd4,  32'd8},
    '{2'd0, 2'd2, 32'h0000_1C00, 32'd0,         7'd3,  32'd12},
    '{2'd0, 2'd3, 32'h0000_2000, 32'd0,         7'd4,  32'd32},
    '{2'd1, 2'd0, 32'h0000_3001, 32'd3,         7'd8,  32'd24},
    '{2'd1, 2'd3, 32'h0000_4000, 32'hFFFF_FFF8, 7'd6,  32'hFFFF_FFD0},
    '{2'd2, 2'd2, 32'h0000_5000, 32'd0,         7'd7,  32'h100},
    '{2'd0, 2'd0, 32'hFFFF_FFF0, 32'd0,         7'd70, 32'd70}
  };

  function automatic logic [31:0] idx_of(int i);
    return 32'(i * 13 - 20);
  endfunction

  function automatic logic [31:0] exp_addr(vec_t v, int i);
    if (v.md[1]) return v.bs + idx_of(i);
    if (v.md == 2'd0) return v.bs + 32'(i) * (32'd1 << v.es);
    return v.bs + 32'(i) * v.st;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(vec_t v);
    @(negedge clk);
    start = 1'b1; mode = v.md; esize = v.es; base = v.bs; stride = v.st;
    vlen = v.n; incr = v.inc; out_ready = 1'b1; idx_valid = 1'b1; idx_data = idx_of(0);
  endtask

  task automatic run_vec(vec_t v, string req);
    launch(v);
    for (int i = 0; i < int'(v.n); i++) begin
      @(negedge clk);
      start = 1'b0; idx_data = idx_of(i);
      #1;
      chk(out_valid && out_addr == exp_addr(v, i), req, out_addr, exp_addr(v, i));
      chk(out_tag == 6'(i), "R5 tag", 32'(out_tag), 32'(6'(i)));
      chk(out_done == (i == int'(v.n) - 1), "R7 done", 32'(out_done), 32'(i == int'(v.n) - 1));
      if (v.md[1]) chk(idx_ready, "R4 idx_ready", 32'(idx_ready), 32'd1);
      if (out_done) chk(new_base == v.bs + v.inc, "R7 new_base", new_base, v.bs + v.inc);
    end
    @(negedge clk); #1;
    chk(!busy && !out_valid, "R10 idle after last", 32'(busy), 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !out_done && !idx_ready, "R1 reset", 32'(busy), 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++)
      run_vec(TBL[k], k == 6 ? "R4 indexed" : (TBL[k].md == 2'd1 ? "R3 stride" : "R2 unit"));

    // R6 stall mid-vector, unit stride word
    v = '{2'd0, 2'd2, 32'h100, 32'd0, 7'd3, 32'd4};
    launch(v);
    @(negedge clk); start = 1'b0; #1;
    chk(out_addr == 32'h100, "R6 first", out_addr, 32'h100);
    @(negedge clk); out_ready = 1'b0; #1;
    chk(out_addr == 32'h104 && out_tag == 6'd1, "R6 before stall", out_addr, 32'h104);
    repeat (2) begin
      @(negedge clk); #1;
      chk(out_valid && out_addr == 32'h104 && out_tag == 6'd1, "R6 held", out_addr, 32'h104);
    end
    @(negedge clk); out_ready = 1'b1; #1;
    chk(out_addr == 32'h104, "R6 still element 1", out_addr, 32'h104);
    @(negedge clk); #1;
    chk(out_addr == 32'h108 && out_done, "R6 resume", out_addr, 32'h108);
    @(negedge clk); #1;
    chk(!busy, "R10 idle", 32'(busy), 32'd0);

    // R4 index stream gap
    v = '{2'd3, 2'd0, 32'h8000, 32'd0, 7'd2, 32'd2};
    launch(v); idx_data = 32'h10;
    @(negedge clk); start = 1'b0; idx_valid = 1'b0; #1;
    chk(!out_valid && !idx_ready, "R4 gap no valid", 32'(out_valid), 32'd0);
    @(negedge clk); idx_valid = 1'b1; idx_data = 32'h10; #1;
    chk(out_valid && idx_ready && out_addr == 32'h8010, "R4 after gap", out_addr, 32'h8010);
    @(negedge clk); idx_data = 32'hFFFF_FFFC; #1;
    chk(out_addr == 32'h7FFC && out_tag == 6'd1 && out_done, "R4 negative index", out_addr, 32'h7FFC);
    @(negedge clk); #1;

    // R8 start during run is ignored
    v = '{2'd1, 2'd0, 32'h600, 32'd2, 7'd3, 32'd6};
    launch(v);
    @(negedge clk); start = 1'b1; base = 32'hDEAD_0000; vlen = 7'd9; incr = 32'd1; #1;
    chk(out_addr == 32'h600, "R8 elem0", out_addr, 32'h600);
    @(negedge clk); #1;
    chk(out_addr == 32'h602, "R8 elem1", out_addr, 32'h602);
    @(negedge clk); start = 1'b0; #1;
    chk(out_addr == 32'h604 && out_done, "R8 count kept", out_addr, 32'h604);
    chk(new_base == 32'h606, "R8 new_base kept", new_base, 32'h606);
    @(negedge clk); #1;
    chk(!busy, "R10 idle after R8 run", 32'(busy), 32'd0);

    // R9 empty vector
    @(negedge clk); start = 1'b1; vlen = 7'd0;
    @(negedge clk); start = 1'b0; #1;
    chk(!busy && !out_valid, "R9 empty start", 32'(busy), 32'd0);

    // R10 back-to-back start right after completion
    run_vec('{2'd0, 2'd1, 32'h40, 32'd0, 7'd1, 32'd2}, "R10 single");
    run_vec('{2'd1, 2'd0, 32'h50, 32'd5, 7'd2, 32'd10}, "R10 next");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule